// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Controller

This block sits between a synchronous host and an asynchronous, fully static read-only memory whose output width is chosen by a select line: sixteen-bit locations when the select is high, eight-bit locations (twice as many) when it is low. The host raises a request with a location index and a byte/word flag. The controller then holds the memory address, chip enable and output enable for a number of clock cycles derived from the memory's timing figures and the clock period. It captures the data and returns it with a one-cycle valid pulse.

In byte mode, the memory's top data pin stops being an output and becomes its lowest address input. The controller therefore drives that pin itself, from bit 0 of the host index, and ignores the upper data lanes. Between accesses the controller keeps both enables released for a float wait. This lets the memory's drivers go quiet before that shared pin can change direction. A new request, and with it any mode change, is only taken while the controller reports ready.

All wait counts are fixed at elaboration. Each is the ceiling of a nanosecond figure divided by the clock period.

Top module: `bwrom_rdctl`

## Requirements
- R1: After reset, ready is 1, chip enable and output enable (both active low) are 1, valid is 0, and the select line is 1 (word mode).
- R2: A word-mode request (flag 0) drives the memory address with index bits [AW-1:0] and the select line high, leaves the top-pin drive enable at 0, and returns all 16 data bits of that location.
- R3: A byte-mode request (flag 1) drives the memory address with index bits [AW:1], the top pin with index bit 0 and its drive enable at 1, and the select line low; it returns the data byte from lanes 7..0 with result bits 15..8 forced to 0.
- R4: Valid is a single-cycle pulse that rises exactly SAMPLE_W cycles after the accept edge. SAMPLE_W is the largest of ceil(address access / period), ceil(enable access / period) and ceil(output-enable access / period), which is 25 at the defaults.
- R5: From the accept edge until the capture edge, chip enable and output enable are both held low, and ready is 0.
- R6: After capture, both enables stay high for FLOAT_W cycles before ready returns. FLOAT_W is the larger of ceil(float time / period) and the remainder needed to reach ceil(read cycle / period), which is 5 at the defaults. The controller never drives the top pin while the memory may still be driving it.
- R7: The byte/word flag and the index are latched only on an accepted request; changing the flag while busy affects neither the select line nor the read in flight.
- R8: A request made while ready is 0 is ignored: it causes no access, no address change and no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request, taken when ready is 1 |
| host_addr | input | AW+1 | Location index (bit AW unused in word mode) |
| host_byte | input | 1 | 1 selects byte mode, 0 word mode |
| ready | output | 1 | Controller idle and able to take a request |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| mem_addr | output | AW | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_wsel | output | 1 | Memory organization select, 1 = word, 0 = byte |
| mem_a_lsb | output | 1 | Value driven onto the top data pin in byte mode |
| mem_a_lsb_oe | output | 1 | Drive enable for the top data pin |
| mem_q | input | 16 | Memory data lines as seen by the controller |

## Verification
Two things can coincide in one cycle: the return to idle after a float wait, and a new request in the opposite mode. When that happens, the top data pin changes direction at the same time as the memory's drivers are supposed to have gone quiet. The bench issues each request on the first ready cycle, alternating between modes, and a memory model keeps driving the top pin for a little under the float time after a word read. A monitor flags any cycle in which both sides drive that pin. The scoreboard judges each returned value and its exact cycle, and the model returns a marker value when it is sampled before its access time has passed.

// File: rtl/bwrom_pkg.sv
`timescale 1ns/1ps
package bwrom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } bw_state_t;

   // Whole clock cycles covering a nanosecond figure.
   function automatic int unsigned wait_cycles(input int unsigned t_ns, input int unsigned p_ns);
      return (t_ns + p_ns - 1) / p_ns;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bwrom_timer.sv
`timescale 1ns/1ps
module bwrom_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/bwrom_seq.sv
`timescale 1ns/1ps
module bwrom_seq
   import bwrom_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 25,
   parameter int unsigned FLOAT_W  = 5,
   parameter int unsigned CW       = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic          tmr_done,
   output logic          ready,
   output logic          accept,
   output logic          capture,
   output logic          active,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val
);
   localparam logic [CW-1:0] LD_ACC = CW'(SAMPLE_W - 1);
   localparam logic [CW-1:0] LD_FLT = CW'((FLOAT_W > 0) ? FLOAT_W - 1 : 0);
   localparam bit            HAS_FLOAT = (FLOAT_W > 0);

   bw_state_t state, state_nx;

   always_comb begin
      ready    = (state == ST_IDLE);
      active   = (state == ST_ACCESS);
      accept   = ready && req;
      capture  = active && tmr_done;
      tmr_load = accept || (capture && HAS_FLOAT);
      tmr_val  = accept ? LD_ACC : LD_FLT;
      state_nx = state;
      case (state)
         ST_IDLE:   if (req) state_nx = ST_ACCESS;
         ST_ACCESS: if (tmr_done) state_nx = HAS_FLOAT ? ST_FLOAT : ST_IDLE;
         ST_FLOAT:  if (tmr_done) state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_nx;
   end

   // R8: no access may start while the previous one is in its float wait
   assert_no_restart_in_float_R8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FLOAT) |=> (state != ST_ACCESS));
endmodule

// File: rtl/bwrom_port.sv
`timescale 1ns/1ps
module bwrom_port #(
   parameter int unsigned AW = 22
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          accept,
   input  logic          capture,
   input  logic [AW:0]   host_addr,
   input  logic          host_byte,
   input  logic [15:0]   mem_q,
   output logic [AW-1:0] mem_addr,
   output logic          mem_wsel,
   output logic          mem_a_lsb,
   output logic          mem_a_lsb_oe,
   output logic [15:0]   rd_data,
   output logic          rd_valid
);
   localparam int unsigned LANES = 2;

   logic [AW:0] lat_addr;
   logic        lat_byte;
   logic [7:0]  lane_q [LANES];

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_addr <= '0;
         lat_byte <= 1'b0;
      end else if (accept) begin
         lat_addr <= host_addr;
         lat_byte <= host_byte;
      end
   end

   always_comb begin
      mem_addr     = lat_byte ? lat_addr[AW:1] : lat_addr[AW-1:0];
      mem_a_lsb    = lat_byte & lat_addr[0];
      mem_a_lsb_oe = lat_byte;
      mem_wsel     = ~lat_byte;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         always_ff @(posedge clk) begin
            if (rst)          lane_q[g] <= '0;
            else if (capture) lane_q[g] <= mem_q[7:0];
         end
      end else begin : g_high
         always_ff @(posedge clk) begin
            if (rst)          lane_q[g] <= '0;
            else if (capture) lane_q[g] <= lat_byte ? 8'h00 : mem_q[8*g +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) rd_valid <= 1'b0;
      else     rd_valid <= capture;
   end

   assign rd_data = {lane_q[1], lane_q[0]};

   // R3: a byte-mode result never carries upper-lane bits
   assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !mem_wsel) |-> (rd_data[15:8] == 8'h00));
endmodule

// File: rtl/bwrom_rdctl.sv
`timescale 1ns/1ps
module bwrom_rdctl
   import bwrom_pkg::*;
#(
   parameter int unsigned AW            = 22,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned T_ADDR_ACC_NS = 100,
   parameter int unsigned T_CE_ACC_NS   = 100,
   parameter int unsigned T_OE_ACC_NS   = 50,
   parameter int unsigned T_FLOAT_NS    = 20,
   parameter int unsigned T_CYCLE_NS    = 100
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic [AW:0]   host_addr,
   input  logic          host_byte,
   output logic          ready,
   output logic [15:0]   rd_data,
   output logic          rd_valid,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_wsel,
   output logic          mem_a_lsb,
   output logic          mem_a_lsb_oe,
   input  logic [15:0]   mem_q
);
   localparam int unsigned SAMPLE_W = max2(max2(wait_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                                wait_cycles(T_CE_ACC_NS, CLK_PERIOD_NS)),
                                           wait_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
   localparam int unsigned RC_W     = wait_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
   localparam int unsigned FLOAT_W  = max2(wait_cycles(T_FLOAT_NS, CLK_PERIOD_NS),
                                           (RC_W > SAMPLE_W) ? RC_W - SAMPLE_W : 0);
   localparam int unsigned CNT_W    = $clog2(max2(SAMPLE_W, FLOAT_W) + 1);

   initial begin
      assert (AW >= 2) else $error("AW must be at least 2");
      assert (CLK_PERIOD_NS > 0) else $error("clock period must be positive");
      assert (T_ADDR_ACC_NS > 0 && T_CE_ACC_NS > 0) else $error("access times must be positive");
   end

   logic              accept, capture, active, tmr_load, tmr_done;
   logic [CNT_W-1:0]  tmr_val;

   bwrom_timer #(.CW(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
   );

   bwrom_seq #(.SAMPLE_W(SAMPLE_W), .FLOAT_W(FLOAT_W), .CW(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .req(req), .tmr_done(tmr_done), .ready(ready),
      .accept(accept), .capture(capture), .active(active),
      .tmr_load(tmr_load), .tmr_val(tmr_val)
   );

   bwrom_port #(.AW(AW)) u_port (
      .clk(clk), .rst(rst), .accept(accept), .capture(capture),
      .host_addr(host_addr), .host_byte(host_byte), .mem_q(mem_q),
      .mem_addr(mem_addr), .mem_wsel(mem_wsel), .mem_a_lsb(mem_a_lsb),
      .mem_a_lsb_oe(mem_a_lsb_oe), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   assign mem_ce_n = ~active;
   assign mem_oe_n = ~active;

   // Run-length counters of the enable line, used only by the checks below.
   localparam logic [CNT_W:0] LOW_SAT  = (CNT_W+1)'(SAMPLE_W + 1);
   localparam logic [CNT_W:0] HIGH_SAT = (CNT_W+1)'(FLOAT_W + 1);
   logic [CNT_W:0] low_run, high_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         low_run  <= '0;
         high_run <= HIGH_SAT;
      end else if (mem_ce_n) begin
         high_run <= (high_run >= HIGH_SAT) ? HIGH_SAT : high_run + 1'b1;
      end else begin
         high_run <= '0;
         low_run  <= (high_run != '0) ? (CNT_W+1)'(1) :
                     ((low_run >= LOW_SAT) ? LOW_SAT : low_run + 1'b1);
      end
   end

   // R5: busy while the memory is enabled
   assert_busy_while_enabled_R5: assert property (@(posedge clk) disable iff (rst)
      !mem_ce_n |-> !ready);

   // R4: valid lasts one cycle
   assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid);

   // R4: data captured after exactly the access wait
   assert_access_window_R4: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> (low_run == (CNT_W+1)'(SAMPLE_W)));

   // R6: enables stay released for the float wait before a new access
   assert_float_gap_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_ce_n) |-> (high_run >= (CNT_W+1)'(FLOAT_W)));

   // R6: top pin only turns to output after the float wait
   assert_pin_turn_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_a_lsb_oe) |-> (high_run >= (CNT_W+1)'(FLOAT_W)));

   // R7: organization select is frozen while busy
   assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (rst)
      !ready |=> $stable(mem_wsel));
endmodule

// File: tb/bwrom_rdctl_test.sv
`timescale 1ns/1ps
module bwrom_mem_model #(
   parameter int unsigned AW     = 22,
   parameter int unsigned ACC_NS = 99,
   parameter int unsigned FLT_NS = 19
) (
   input  logic [AW-1:0] a,
   input  logic          a_lsb,
   input  logic          a_lsb_oe,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          wsel,
   output logic [15:0]   q,
   output logic          q15_drv
);
   int ev  = 0;
   int fev = 0;

   function automatic logic [15:0] word_at(input logic [AW-1:0] wa);
      logic [15:0] t;
      t = 16'(wa[15:0] * 16'h9E37);
      return t ^ {wa[21:16], wa[21:12]};
   endfunction

   function automatic logic [15:0] content();
      logic [15:0] w;
      if (ce_n || oe_n) return 16'hBAD5;
      w = word_at(a);
      if (wsel) return w;
      if (!a_lsb_oe) return 16'hBAD5;
      return {a_lsb, 7'h7F, a_lsb ? w[15:8] : w[7:0]};
   endfunction

   task automatic settle(input int id);
      #(ACC_NS);
      if (id == ev) q = content();
   endtask

   task automatic release_pin(input int id);
      #(FLT_NS);
      if (id == fev) q15_drv = 1'b0;
   endtask

   initial begin
      q = 16'hBAD5;
      q15_drv = 1'b0;
   end

   always @(a or a_lsb or a_lsb_oe or ce_n or oe_n or wsel) begin
      ev = ev + 1;
      q = 16'hBAD5;
      fork
         settle(ev);
      join_none
   end

   always @(ce_n or oe_n or wsel) begin
      fev = fev + 1;
      if (!ce_n && !oe_n && wsel) q15_drv = 1'b1;
      else if (q15_drv) begin
         fork
            release_pin(fev);
         join_none
      end
   end
endmodule

module bwrom_rdctl_test;
   localparam int unsigned AW = 22;
   localparam int unsigned PERIOD = 4;

   function automatic int unsigned cdiv(input int unsigned t, input int unsigned p);
      return (t + p - 1) / p;
   endfunction
   localparam int unsigned W_EXP = 25;  // max(ceil(100/4), ceil(50/4))
   localparam int unsigned F_EXP = 5;   // max(ceil(20/4), ceil(100/4)-25)

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic [AW:0]   host_addr = '0;
   logic          host_byte = 1'b0;
   logic          ready, rd_valid, mem_ce_n, mem_oe_n, mem_wsel, mem_a_lsb, mem_a_lsb_oe;
   logic          q15_drv;
   logic [15:0]   rd_data, mem_q;
   logic [AW-1:0] mem_addr;

   always #(PERIOD/2) clk = ~clk;

   bwrom_rdctl uut (
      .clk(clk), .rst(rst), .req(req), .host_addr(host_addr), .host_byte(host_byte),
      .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_wsel(mem_wsel),
      .mem_a_lsb(mem_a_lsb), .mem_a_lsb_oe(mem_a_lsb_oe), .mem_q(mem_q)
   );

   bwrom_mem_model #(.AW(AW)) u_mem (
      .a(mem_addr), .a_lsb(mem_a_lsb), .a_lsb_oe(mem_a_lsb_oe), .ce_n(mem_ce_n),
      .oe_n(mem_oe_n), .wsel(mem_wsel), .q(mem_q), .q15_drv(q15_drv)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] word_ref(input logic [AW-1:0] wa);
      logic [15:0] t;
      t = 16'(wa[15:0] * 16'h9E37);
      return t ^ {wa[21:16], wa[21:12]};
   endfunction

   function automatic logic [15:0] exp_data(input logic [AW:0] a, input logic bm);
      logic [15:0] w;
      if (!bm) return word_ref(a[AW-1:0]);
      w = word_ref(a[AW:1]);
      return {8'h00, a[0] ? w[15:8] : w[7:0]};
   endfunction

   typedef struct {
      logic [15:0] d;
      int          c;
      string       tag;
   } exp_t;
   exp_t sb[$];

   // Driver: issue one read; optionally poke req and the mode flag while busy.
   task automatic do_read(input logic [AW:0] a, input logic bm, input bit poke, input string tag);
      int c0;
      exp_t e;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; host_addr = a; host_byte = bm;
      @(posedge clk); #1;
      c0 = cyc;
      e.d = exp_data(a, bm); e.c = c0 + int'(W_EXP); e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req = 1'b0;
      chk(!mem_ce_n && !mem_oe_n && !ready, "R5 enables low and not ready", {mem_ce_n, mem_oe_n, ready}, 0);
      chk(mem_addr == (bm ? a[AW:1] : a[AW-1:0]), bm ? "R3 byte address" : "R2 word address",
          mem_addr, bm ? a[AW:1] : a[AW-1:0]);
      chk(mem_wsel == !bm && mem_a_lsb_oe == bm, bm ? "R3 select/pin drive" : "R2 select/pin drive",
          {mem_wsel, mem_a_lsb_oe}, {!bm, bm});
      if (bm) chk(mem_a_lsb == a[0], "R3 top pin carries index bit 0", mem_a_lsb, a[0]);
      if (poke) begin
         repeat (3) @(negedge clk);
         host_byte = ~bm; req = 1'b1; host_addr = ~a;
         repeat (5) @(negedge clk);
         chk(mem_wsel == !bm, "R7 select unchanged by flag while busy", mem_wsel, !bm);
         chk(mem_addr == (bm ? a[AW:1] : a[AW-1:0]), "R8 address unchanged by request while busy",
             mem_addr, bm ? a[AW:1] : a[AW-1:0]);
         req = 1'b0;
      end
      while (!ready) @(negedge clk);
      chk(cyc == c0 + int'(W_EXP + F_EXP), "R6 ready returns after float wait", cyc, c0 + int'(W_EXP + F_EXP));
   endtask

   // Monitor: pop and compare results; watch the shared pin.
   always @(negedge clk) begin
      if (!rst) begin
         if (rd_valid) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R8 unexpected valid pulse", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(rd_data == e.d, e.tag, rd_data, e.d);
               chk(cyc == e.c, "R4 valid cycle", cyc, e.c);
            end
         end
         if (mem_a_lsb_oe && q15_drv) chk(1'b0, "R6 top pin contention", 1, 0);
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(ready == 1'b1, "R1 ready after reset", ready, 1);
      chk(mem_ce_n && mem_oe_n, "R1 enables released", {mem_ce_n, mem_oe_n}, 2'b11);
      chk(rd_valid == 1'b0, "R1 no valid after reset", rd_valid, 0);
      chk(mem_wsel == 1'b1 && mem_a_lsb_oe == 1'b0, "R1 word mode after reset", {mem_wsel, mem_a_lsb_oe}, 2'b10);

      do_read(23'h000000, 1'b0, 1'b0, "R2 word data at 0");
      do_read(23'h3FFFFF, 1'b0, 1'b0, "R2 word data at top");
      do_read(23'h000000, 1'b1, 1'b0, "R3 byte data even");
      do_read(23'h000001, 1'b1, 1'b0, "R3 byte data odd");
      do_read(23'h7FFFFF, 1'b1, 1'b0, "R3 byte data at top");
      do_read(23'h412345, 1'b0, 1'b0, "R2 word after byte");
      do_read(23'h02468B, 1'b1, 1'b0, "R3 byte right after word");
      do_read(23'h135791, 1'b0, 1'b1, "R7 word read with flag flipped");
      do_read(23'h2ACE03, 1'b1, 1'b1, "R7 byte read with flag flipped");
      for (int i = 0; i < 8; i++) begin
         logic [AW:0] a;
         a = 23'(i * 32'h0009_E3B5 + 7);
         do_read(a, i[0], 1'b0, i[0] ? "R3 byte sweep" : "R2 word sweep");
      end
      repeat (10) @(negedge clk);
      chk(sb.size() == 0, "R4 every read returned", sb.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule